// File: doc/BRIEF.md
# PWM Scaled Clock-Enable Generator

This block sits at the clock front end of an eight-channel pulse-width modulator. Two base clock-enable pulse trains, A and B, come in from an upstream prescaler. Each train feeds its own scaled path. A scaled path has a programmable down counter and a divide-by-two flop, and it produces a slower enable pulse train, SA or SB. All four trains are single-cycle enable pulses in the system clock domain. No generated clocks are involved.

For each channel, a select register picks either the base train or the scaled train of that channel's group. The result goes out as a per-channel enable vector for the channel counters downstream. Software programs one scale value for each path and the channel select bits, each through its own write strobe. Writing a scale value restarts that path at once with the new value.

Top module: `pwm_scaled_clkgen`

## Requirements
- R1: A synchronous reset (`rst` high) sets both scale values to 0 (treated as 256), empties both scaled paths and clears every select bit, so that each channel follows its base train.
- R2: A scaled pulse is high for one system cycle only, and only in a cycle where its own base tick input is high.
- R3: For a scale value N in 1..255, the scaled output pulses on every 2N-th base tick counted after the latest write or reset, so that N=1 divides by 2 and N=255 divides by 510.
- R4: A scale value of 0 counts as 256, so the scaled output pulses on every 512th base tick.
- R5: A write to a scale value restarts the path with the new value, whatever the old count was. The first scaled pulse then comes on the 2N-th base tick after the write cycle.
- R6: In a cycle with a scale write, a base tick of the same path is not counted and no scaled pulse of that path is issued.
- R7: Channels whose index has bit 1 equal to 0 (channels 0, 1, 4, 5) take train A or SA. Channels whose index has bit 1 equal to 1 (channels 2, 3, 6, 7) take train B or SB.
- R8: Select bit i = 0 routes the base train to `ch_en[i]`, and select bit i = 1 routes the scaled train to `ch_en[i]`. The routing is combinational in the same cycle.
- R9: A select write loads all eight select bits from `sel_data`. The new routing takes effect in the cycle after the write cycle.
- R10: When no base tick and no write occur, a path keeps its position. Idle cycles neither shift nor produce scaled pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_a | input | 1 | Base enable pulse A |
| tick_b | input | 1 | Base enable pulse B |
| scale_a_wr | input | 1 | Write strobe for scale value A |
| scale_a_data | input | 8 | New scale value A (0 means 256) |
| scale_b_wr | input | 1 | Write strobe for scale value B |
| scale_b_data | input | 8 | New scale value B (0 means 256) |
| sel_wr | input | 1 | Write strobe for the channel select bits |
| sel_data | input | 8 | New select bits, bit i for channel i |
| scaled_a | output | 1 | Scaled enable pulse SA |
| scaled_b | output | 1 | Scaled enable pulse SB |
| ch_en | output | 8 | Per-channel enable pulses |

## Verification
The scaled pulses and the channel enables are combinational from the registered state and the tick inputs, so they are due in the same cycle as the base tick that completes a period. The bench drives inputs just after a rising edge and samples all outputs at the following falling edge. Scale writes act on the next edge, so the write cycle itself shows no scaled pulse, and the bench's tick count restarts from the following cycle. Select writes become visible one cycle later, and the bench's select model updates only after the write cycle has been compared. Every cycle is compared against an arithmetic expectation: a pulse is due when the tick count since the last write is a multiple of twice the effective scale. The scale sweep covers every value from 1 to 255 and 0, and all 256 select patterns.

// File: rtl/pwm_sclk_pkg.sv
package pwm_sclk_pkg;

   // Source picked for one channel by its select bit
   typedef enum logic {
      SRC_BASE   = 1'b0,
      SRC_SCALED = 1'b1
   } clk_src_e;

   // Group of a channel: bit 1 of the index (0 -> path A, 1 -> path B)
   function automatic bit group_of(input int unsigned ch);
      return ((ch >> 1) & 1) != 0;
   endfunction

endpackage

// File: rtl/pwm_scale_path.sv
module pwm_scale_path #(
   parameter int SCALE_W = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               tick,
   input  logic               wr,
   input  logic [SCALE_W-1:0] wdata,
   output logic               pulse
);
   localparam int CNT_W = SCALE_W + 1;
   localparam logic [CNT_W-1:0] FULL = CNT_W'(1) << SCALE_W;
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   generate
      if (SCALE_W < 1 || SCALE_W > 16) begin : g_bad_width
         $error("pwm_scale_path: SCALE_W must be in 1..16");
      end
   endgenerate

   logic [SCALE_W-1:0] scale_q;
   logic [CNT_W-1:0]   cnt_q;
   logic               half_q;
   logic               wrap;

   function automatic logic [CNT_W-1:0] expand(input logic [SCALE_W-1:0] v);
      return (v == '0) ? FULL : {1'b0, v};
   endfunction

   assign wrap  = tick && !wr && (cnt_q == ONE);
   assign pulse = wrap && half_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         scale_q <= '0;
         cnt_q   <= FULL;
         half_q  <= 1'b0;
      end else if (wr) begin
         scale_q <= wdata;
         cnt_q   <= expand(wdata);
         half_q  <= 1'b0;
      end else if (tick) begin
         if (cnt_q == ONE) begin
            cnt_q  <= expand(scale_q);
            half_q <= ~half_q;
         end else begin
            cnt_q <= cnt_q - ONE;
         end
      end
   end

   // R3: the count always stays in 1..2**SCALE_W
   p_cnt_range_r3: assert property (@(posedge clk) disable iff (rst)
      (cnt_q != '0) && (cnt_q <= FULL));

   // R5: a write restarts the count from the written value
   p_reload_on_write_r5: assert property (@(posedge clk) disable iff (rst)
      wr |=> (cnt_q == expand($past(wdata))) && !half_q && (scale_q == $past(wdata)));

   // R10: no tick and no write leave the path untouched
   p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
      (!tick && !wr) |=> $stable(cnt_q) && $stable(half_q));

   // R2: after a scaled pulse the half flop is back at zero
   p_pulse_clears_half_r2: assert property (@(posedge clk) disable iff (rst)
      pulse |=> !half_q);

   // R6: a write cycle never carries a scaled pulse
   p_no_pulse_on_write_r6: assert property (@(posedge clk) disable iff (rst)
      wr |-> !pulse);

endmodule

// File: rtl/pwm_clk_route.sv
module pwm_clk_route
   import pwm_sclk_pkg::*;
#(
   parameter int NUM_CH = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              base_a,
   input  logic              base_b,
   input  logic              scaled_a,
   input  logic              scaled_b,
   input  logic              sel_wr,
   input  logic [NUM_CH-1:0] sel_data,
   output logic [NUM_CH-1:0] ch_en
);
   generate
      if (NUM_CH < 1 || NUM_CH > 64) begin : g_bad_count
         $error("pwm_clk_route: NUM_CH must be in 1..64");
      end
   endgenerate

   logic [NUM_CH-1:0] sel_q;

   always_ff @(posedge clk) begin
      if (rst)         sel_q <= '0;
      else if (sel_wr) sel_q <= sel_data;
   end

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         clk_src_e src;
         assign src = clk_src_e'(sel_q[i]);
         if (!group_of(i)) begin : g_grp_a
            assign ch_en[i] = (src == SRC_SCALED) ? scaled_a : base_a;
            // R7: an enable of a group-A channel always sits on an A tick
            p_grp_a_on_tick_r7: assert property (@(posedge clk) disable iff (rst)
               ch_en[i] |-> base_a);
         end else begin : g_grp_b
            assign ch_en[i] = (src == SRC_SCALED) ? scaled_b : base_b;
            // R7: an enable of a group-B channel always sits on a B tick
            p_grp_b_on_tick_r7: assert property (@(posedge clk) disable iff (rst)
               ch_en[i] |-> base_b);
         end
      end
   endgenerate

   // R9: a select write is visible from the next cycle on
   p_sel_load_r9: assert property (@(posedge clk) disable iff (rst)
      sel_wr |=> (sel_q == $past(sel_data)));

endmodule

// File: rtl/pwm_scaled_clkgen.sv
module pwm_scaled_clkgen #(
   parameter int SCALE_W = 8,
   parameter int NUM_CH  = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               tick_a,
   input  logic               tick_b,
   input  logic               scale_a_wr,
   input  logic [SCALE_W-1:0] scale_a_data,
   input  logic               scale_b_wr,
   input  logic [SCALE_W-1:0] scale_b_data,
   input  logic               sel_wr,
   input  logic [NUM_CH-1:0]  sel_data,
   output logic               scaled_a,
   output logic               scaled_b,
   output logic [NUM_CH-1:0]  ch_en
);
   localparam int NUM_PATH = 2;

   logic [NUM_PATH-1:0] tick_v;
   logic [NUM_PATH-1:0] wr_v;
   logic [NUM_PATH-1:0] pulse_v;
   logic [SCALE_W-1:0]  data_v [NUM_PATH];

   assign tick_v    = {tick_b, tick_a};
   assign wr_v      = {scale_b_wr, scale_a_wr};
   assign data_v[0] = scale_a_data;
   assign data_v[1] = scale_b_data;

   generate
      for (genvar p = 0; p < NUM_PATH; p++) begin : g_path
         pwm_scale_path #(.SCALE_W(SCALE_W)) i_path (
            .clk   (clk),
            .rst   (rst),
            .tick  (tick_v[p]),
            .wr    (wr_v[p]),
            .wdata (data_v[p]),
            .pulse (pulse_v[p])
         );
         // R2: a scaled pulse only ever coincides with its own base tick
         p_scaled_on_base_r2: assert property (@(posedge clk) disable iff (rst)
            pulse_v[p] |-> tick_v[p]);
      end
   endgenerate

   assign scaled_a = pulse_v[0];
   assign scaled_b = pulse_v[1];

   pwm_clk_route #(.NUM_CH(NUM_CH)) i_route (
      .clk      (clk),
      .rst      (rst),
      .base_a   (tick_a),
      .base_b   (tick_b),
      .scaled_a (pulse_v[0]),
      .scaled_b (pulse_v[1]),
      .sel_wr   (sel_wr),
      .sel_data (sel_data),
      .ch_en    (ch_en)
   );

   // R1: in the cycle right after reset no scaled pulse can be present
   p_reset_quiet_r1: assert property (@(posedge clk)
      rst |=> !scaled_a && !scaled_b);

endmodule

// File: tb/test_pwm_scaled_clkgen.sv
module test_pwm_scaled_clkgen;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       tick_a = 1'b0, tick_b = 1'b0;
   logic       scale_a_wr = 1'b0, scale_b_wr = 1'b0, sel_wr = 1'b0;
   logic [7:0] scale_a_data = '0, scale_b_data = '0, sel_data = '0;
   logic       scaled_a, scaled_b;
   logic [7:0] ch_en;

   int vectors = 0;
   int fails   = 0;
   int cyc     = 0;
   string cur_req = "R1";

   // bench model: ticks counted since the last write, effective scale, selects
   int         ka = 0, kb = 0;
   int         effa = 256, effb = 256;
   logic [7:0] sel_m = '0;

   always #5 clk = ~clk;

   pwm_scaled_clkgen i_pwm_scaled_clkgen (
      .clk(clk), .rst(rst), .tick_a(tick_a), .tick_b(tick_b),
      .scale_a_wr(scale_a_wr), .scale_a_data(scale_a_data),
      .scale_b_wr(scale_b_wr), .scale_b_data(scale_b_data),
      .sel_wr(sel_wr), .sel_data(sel_data),
      .scaled_a(scaled_a), .scaled_b(scaled_b), .ch_en(ch_en)
   );

   task automatic finish_up;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 190000) begin
         fails = fails + 1;
         $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
         finish_up();
      end
   end

   task automatic step(input logic ta, input logic tb,
                       input logic wa, input logic [7:0] da,
                       input logic wb, input logic [7:0] db,
                       input logic sw, input logic [7:0] sd);
      logic esa, esb;
      logic [7:0] ech;
      tick_a = ta; tick_b = tb;
      scale_a_wr = wa; scale_a_data = da;
      scale_b_wr = wb; scale_b_data = db;
      sel_wr = sw; sel_data = sd;
      @(negedge clk);
      esa = ta && !wa && (((ka + 1) % (2 * effa)) == 0);
      esb = tb && !wb && (((kb + 1) % (2 * effb)) == 0);
      for (int i = 0; i < 8; i++) begin
         if (((i >> 1) & 1) == 0) ech[i] = sel_m[i] ? esa : ta;
         else                     ech[i] = sel_m[i] ? esb : tb;
      end
      vectors = vectors + 1;
      if (scaled_a !== esa || scaled_b !== esb) begin
         fails = fails + 1;
         $display("FAIL %s scaled pulses: actual=%b%b expected=%b%b (ka=%0d effa=%0d kb=%0d effb=%0d)",
                  cur_req, scaled_a, scaled_b, esa, esb, ka, effa, kb, effb);
      end
      vectors = vectors + 1;
      if (ch_en !== ech) begin
         fails = fails + 1;
         $display("FAIL R7/R8 (%s) ch_en: actual=%b expected=%b sel=%b",
                  cur_req, ch_en, ech, sel_m);
      end
      if (wa) begin effa = (da == 0) ? 256 : int'(da); ka = 0; end
      else if (ta) ka = ka + 1;
      if (wb) begin effb = (db == 0) ? 256 : int'(db); kb = 0; end
      else if (tb) kb = kb + 1;
      if (sw) sel_m = sd;
      @(posedge clk); #1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;

      // R1: reset state, both paths at 256 and all channels on base trains
      cur_req = "R1";
      for (int k = 0; k < 8; k++) step(k[0], k[1], 0, 0, 0, 0, 0, 0);

      // R4: default scale 0 on A with a tick every cycle; B gets an explicit 0
      cur_req = "R4";
      step(1, 1, 0, 0, 1, 8'h00, 1, 8'hFF);
      for (int k = 0; k < 1100; k++) step(1, 1, 0, 0, 0, 0, 0, 0);

      // R3 and R9: every scale 1..255 on A, selects swept through all patterns
      cur_req = "R3";
      for (int n = 1; n < 256; n++) begin
         step(1, 0, 1, 8'(n), 1, 8'((n % 4) + 1), 1, 8'(n));
         for (int k = 0; k < 2 * n + 2; k++) step(1, (k % 3) == 0, 0, 0, 0, 0, 0, 0);
      end
      cur_req = "R9";
      step(0, 0, 0, 0, 0, 0, 1, 8'h00);
      for (int k = 0; k < 6; k++) step(1, 1, 0, 0, 0, 0, 0, 0);

      // R5: a mid-count rewrite restarts from the new value
      cur_req = "R5";
      step(0, 0, 1, 8'd200, 1, 8'd150, 1, 8'hF0);
      for (int k = 0; k < 10; k++) step(1, 1, 0, 0, 0, 0, 0, 0);
      step(0, 0, 1, 8'd3, 1, 8'd2, 0, 0);
      for (int k = 0; k < 20; k++) step(1, 1, 0, 0, 0, 0, 0, 0);

      // R6: write together with the tick that would have pulsed
      cur_req = "R6";
      step(0, 0, 1, 8'd1, 1, 8'd1, 1, 8'h55);
      step(1, 1, 0, 0, 0, 0, 0, 0);
      step(1, 1, 1, 8'd1, 1, 8'd1, 0, 0);
      for (int k = 0; k < 8; k++) step(1, 1, 0, 0, 0, 0, 0, 0);

      // R10: idle cycles hold position, then counting resumes
      cur_req = "R10";
      step(0, 0, 1, 8'd4, 1, 8'd5, 1, 8'hFF);
      for (int k = 0; k < 5; k++) step(1, 1, 0, 0, 0, 0, 0, 0);
      for (int k = 0; k < 60; k++) step(0, 0, 0, 0, 0, 0, 0, 0);
      for (int k = 0; k < 40; k++) step(1, (k % 2) == 0, 0, 0, 0, 0, 0, 0);

      // R1 again: reset in the middle of activity
      cur_req = "R1";
      rst = 1'b1;
      @(posedge clk); #1;
      rst = 1'b0;
      ka = 0; kb = 0; effa = 256; effb = 256; sel_m = '0;
      for (int k = 0; k < 8; k++) step(1, k[0], 0, 0, 0, 0, 0, 0);

      finish_up();
   end
endmodule